// File: doc/BRIEF.md
# Request-Driven Counter Snapshot Across Clock Domains

This block keeps a free-running binary counter in a source clock domain and lets logic in an unrelated destination clock domain obtain a coherent copy of it. The destination never samples the live counter bits, because a destination edge can land while those bits are still settling and return a mix of old and new bits. Instead, the destination raises a request. The source domain answers by copying the counter into a holding register that the source clock owns. The destination then takes that register once it knows the register has stopped changing.

The request flag is shared between the two domains. The destination sets it and the source clears it. It is formed from one toggle flop in each domain, and the flag is the XOR of the two. Each side brings the other side's toggle in through a multi-stage synchronizer. When the source first sees the flag raised, it lets one full source clock pass. On the next source edge it loads the holding register and flips its own toggle, which clears the flag. The destination waits until the flag reads clear. It then captures the holding register and issues a single-cycle valid pulse with the value.

Top module: `snap_counter_xfer`

## Requirements
- R1: After reset the counter is 0. On each source clock edge where `cnt_en` is high it advances by the parameter `STEP`, modulo 2^`CNT_W`, and it holds its value when `cnt_en` is low.
- R2: While `rst_d_n` is low, `snap_valid` is 0 and `snap_data` is 0.
- R3: Every delivered `snap_data` equals a value that the counter held at some point between the destination edge that accepted the request and the destination edge that raised `snap_valid`.
- R4: The source loads the holding register only after it has seen the synchronized flag high on two consecutive source edges. With two synchronizer stages and the bench clocks, `snap_valid` therefore rises no earlier than the 7th destination edge after the accepting edge.
- R5: On one source edge, the holding register is loaded and the source toggle flips, which clears the flag. A request is answered within 12 destination edges of its acceptance.
- R6: `snap_valid` is high for exactly one destination clock per answered request. `snap_data` changes only on the edge that raises `snap_valid`.
- R7: A request that arrives while an earlier one is still pending is ignored and produces no extra `snap_valid` pulse. A request is accepted on any destination edge where `rd_req` is high and no request is pending.
- R8: While the counter runs, successive snapshots never go backwards. The forward distance from one snapshot to the next, modulo 2^`CNT_W`, is less than half the counter range.
- R9: While `cnt_en` is held low, every snapshot equals the frozen counter value exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Source (counter) clock |
| rst_s_n | input | 1 | Source domain asynchronous reset, active low |
| cnt_en | input | 1 | Counter advance enable, source domain |
| clk_d | input | 1 | Destination (reader) clock |
| rst_d_n | input | 1 | Destination domain asynchronous reset, active low |
| rd_req | input | 1 | Snapshot request, sampled on each destination edge |
| snap_valid | output | 1 | One-cycle pulse marking a new snapshot |
| snap_data | output | CNT_W | Last captured counter value |

## Verification
The source clock runs at a non-integer ratio to the destination clock, so the phase at which requests arrive sweeps across the source period. Single isolated requests with growing gaps check the latency window. Too short a window points to a missing holdoff clock (R4), and too long a window points to a stalled flag clear (R5). A request held high for hundreds of cycles checks that a pending request blocks new ones, and it runs the counter through several wraps to test the no-backwards rule. A pseudo-random enable then makes the counter change irregularly, which tests the window check in R3. A frozen counter, finally, pins down the exact value and the step size.

// File: rtl/snap_xfer_pkg.sv
`timescale 1ns/1ps
package snap_xfer_pkg;

   // fewest synchronizer flops accepted on either crossing
   localparam int MIN_SYNC_STAGES = 2;

   // source side: idle, or spending the one-clock holdoff before the copy
   typedef enum logic {
      SRC_IDLE    = 1'b0,
      SRC_HOLDOFF = 1'b1
   } src_state_e;

   // destination side: idle, or waiting for the flag to read clear
   typedef enum logic {
      DST_IDLE = 1'b0,
      DST_PEND = 1'b1
   } dst_state_e;

endpackage

// File: rtl/snap_sync.sv
`timescale 1ns/1ps
module snap_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   generate
      if (STAGES < snap_xfer_pkg::MIN_SYNC_STAGES) begin : g_bad_depth
         $error("snap_sync: STAGES below minimum");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q <= {stg_q[LAST-1:0], d};
      end
   end

   assign q = stg_q[LAST];

endmodule

// File: rtl/snap_src.sv
`timescale 1ns/1ps
module snap_src
   import snap_xfer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int STEP        = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             req_tog_a,
   output logic             ack_tog,
   output logic             flag_seen,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] hold_q
);

   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   logic       req_sync;
   src_state_e state_q;

   snap_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (1)
   ) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_tog_a),
      .q     (req_sync)
   );

   // shared flag as seen from this domain
   assign flag_seen = req_sync ^ ack_tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_en) begin
         cnt_q <= cnt_q + STEP_V;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SRC_IDLE;
         ack_tog <= 1'b0;
         hold_q  <= '0;
      end else begin
         unique case (state_q)
            SRC_IDLE: begin
               if (flag_seen) begin
                  state_q <= SRC_HOLDOFF;
               end
            end
            SRC_HOLDOFF: begin
               hold_q  <= cnt_q;
               ack_tog <= ~ack_tog;
               state_q <= SRC_IDLE;
            end
            default: state_q <= SRC_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/snap_dst.sv
`timescale 1ns/1ps
module snap_dst
   import snap_xfer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             ack_tog_a,
   input  logic [CNT_W-1:0] hold_a,
   output logic             req_tog,
   output logic             busy,
   output logic             snap_valid,
   output logic [CNT_W-1:0] snap_data
);

   logic       ack_sync;
   logic       flag_clear;
   dst_state_e state_q;

   snap_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (1)
   ) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_tog_a),
      .q     (ack_sync)
   );

   // flag reads clear once the source toggle has caught up
   assign flag_clear = (req_tog == ack_sync);
   assign busy       = (state_q == DST_PEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= DST_IDLE;
         req_tog    <= 1'b0;
         snap_valid <= 1'b0;
         snap_data  <= '0;
      end else begin
         snap_valid <= 1'b0;
         unique case (state_q)
            DST_IDLE: begin
               if (rd_req) begin
                  req_tog <= ~req_tog;
                  state_q <= DST_PEND;
               end
            end
            DST_PEND: begin
               if (flag_clear) begin
                  snap_data  <= hold_a;
                  snap_valid <= 1'b1;
                  state_q    <= DST_IDLE;
               end
            end
            default: state_q <= DST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/snap_counter_xfer.sv
`timescale 1ns/1ps
module snap_counter_xfer #(
   parameter int CNT_W       = 16,
   parameter int STEP        = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_s,
   input  logic             rst_s_n,
   input  logic             cnt_en,
   input  logic             clk_d,
   input  logic             rst_d_n,
   input  logic             rd_req,
   output logic             snap_valid,
   output logic [CNT_W-1:0] snap_data
);

   localparam longint CNT_RANGE = longint'(1) << CNT_W;

   generate
      if (CNT_W < 2 || CNT_W > 62) begin : g_bad_width
         $error("snap_counter_xfer: CNT_W out of range");
      end
      if (STEP < 1 || longint'(STEP) >= CNT_RANGE) begin : g_bad_step
         $error("snap_counter_xfer: STEP out of range");
      end
      if (SYNC_STAGES < snap_xfer_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
         $error("snap_counter_xfer: SYNC_STAGES too small");
      end
   endgenerate

   logic             req_tog;
   logic             ack_tog;
   logic             flag_seen;
   logic             busy;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hold_q;

   snap_src #(
      .CNT_W       (CNT_W),
      .STEP        (STEP),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk       (clk_s),
      .rst_n     (rst_s_n),
      .cnt_en    (cnt_en),
      .req_tog_a (req_tog),
      .ack_tog   (ack_tog),
      .flag_seen (flag_seen),
      .cnt_q     (cnt_q),
      .hold_q    (hold_q)
   );

   snap_dst #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_dst (
      .clk        (clk_d),
      .rst_n      (rst_d_n),
      .rd_req     (rd_req),
      .ack_tog_a  (ack_tog),
      .hold_a     (hold_q),
      .req_tog    (req_tog),
      .busy       (busy),
      .snap_valid (snap_valid),
      .snap_data  (snap_data)
   );

endmodule

// File: rtl/snap_counter_xfer_chk.sv
`timescale 1ns/1ps
module snap_counter_xfer_chk #(
   parameter int CNT_W = 16,
   parameter int STEP  = 1
) (
   input logic             clk_s,
   input logic             rst_s_n,
   input logic             cnt_en,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] hold_q,
   input logic             ack_tog,
   input logic             flag_seen,
   input logic             clk_d,
   input logic             rst_d_n,
   input logic             rd_req,
   input logic             req_tog,
   input logic             busy,
   input logic             snap_valid,
   input logic [CNT_W-1:0] snap_data
);

   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   // R1: counter advances by STEP when enabled, holds otherwise
   p_count_step_r1: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      $past(rst_s_n) |-> (cnt_q == $past(cnt_q) + ($past(cnt_en) ? STEP_V : '0)));

   // R4: the copy follows two consecutive samples of a raised flag
   p_holdoff_r4: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      $changed(ack_tog) |-> ($past(flag_seen) && $past(flag_seen, 2)));

   // R5: holding register moves only together with the flag clear
   p_load_with_clear_r5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      !$stable(hold_q) |-> !$stable(ack_tog));

   // R6: valid is a single-cycle pulse
   p_valid_single_r6: assert property (@(posedge clk_d) disable iff (!rst_d_n)
      snap_valid |=> !snap_valid);

   // R6: output data is quiet between pulses
   p_data_quiet_r6: assert property (@(posedge clk_d) disable iff (!rst_d_n)
      !snap_valid |-> $stable(snap_data));

   // R7: a pending request blocks a new toggle
   p_no_overlap_r7: assert property (@(posedge clk_d) disable iff (!rst_d_n)
      (busy && rd_req) |=> $stable(req_tog));

   // R3: the delivered value is the settled holding register
   p_snap_from_hold_r3: assert property (@(posedge clk_d) disable iff (!rst_d_n || !rst_s_n)
      snap_valid |-> (snap_data == hold_q));

endmodule

bind snap_counter_xfer snap_counter_xfer_chk #(
   .CNT_W (CNT_W),
   .STEP  (STEP)
) u_chk (
   .clk_s      (clk_s),
   .rst_s_n    (rst_s_n),
   .cnt_en     (cnt_en),
   .cnt_q      (cnt_q),
   .hold_q     (hold_q),
   .ack_tog    (ack_tog),
   .flag_seen  (flag_seen),
   .clk_d      (clk_d),
   .rst_d_n    (rst_d_n),
   .rd_req     (rd_req),
   .req_tog    (req_tog),
   .busy       (busy),
   .snap_valid (snap_valid),
   .snap_data  (snap_data)
);

// File: tb/sim_snap_counter_xfer.sv
`timescale 1ns/1ps
module sim_snap_counter_xfer;

   localparam int W    = 8;
   localparam int STEP = 3;
   localparam int SYNC = 2;
   localparam int MOD  = 1 << W;
   localparam int LAT_MIN = 7;
   localparam int LAT_MAX = 12;

   logic         clk_s = 1'b0;
   logic         clk_d = 1'b0;
   logic         rst_s_n = 1'b0;
   logic         rst_d_n = 1'b0;
   logic         cnt_en = 1'b0;
   logic         rd_req = 1'b0;
   logic         snap_valid;
   logic [W-1:0] snap_data;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // 250 MHz reader clock, counter clock at a 1.54 ratio
   always #2 clk_d = ~clk_d;
   initial begin
      #1;
      forever #3.08 clk_s = ~clk_s;
   end

   snap_counter_xfer #(
      .CNT_W       (W),
      .STEP        (STEP),
      .SYNC_STAGES (SYNC)
   ) u0 (
      .clk_s      (clk_s),
      .rst_s_n    (rst_s_n),
      .cnt_en     (cnt_en),
      .clk_d      (clk_d),
      .rst_d_n    (rst_d_n),
      .rd_req     (rd_req),
      .snap_valid (snap_valid),
      .snap_data  (snap_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // enable driver: 0 = run, 1 = frozen, 2 = pseudo-random
   int          en_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk_s) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (en_mode)
         0:       cnt_en <= 1'b1;
         1:       cnt_en <= 1'b0;
         default: cnt_en <= lfsr[0] ^ lfsr[5];
      endcase
   end

   // behavioural counter model
   int model = 0;
   always @(posedge clk_s or negedge rst_s_n) begin
      if (!rst_s_n)    model <= 0;
      else if (cnt_en) model <= (model + STEP) % MOD;
   end

   // request as seen by the design at each reader edge
   bit req_smp = 0;
   always @(posedge clk_d) req_smp <= rd_req && rst_d_n;

   // per-clock comparison against the request model
   bit pend = 0;
   bit mon_on = 0;
   bit frozen = 0;
   bit last_valid = 0;
   int lat = 0;
   int lo = 0;
   int prev_snap = -1;
   int last_data = 0;
   int n_snap = 0;
   always @(negedge clk_d) begin
      if (mon_on) begin
         int sd;
         sd = int'(snap_data);
         chk(!(last_valid && snap_valid), "R6 pulse width", 2, 1);
         if (!snap_valid) chk(sd == last_data, "R6 data held", sd, last_data);
         if (pend) begin
            lat++;
            if (snap_valid) begin
               int span;
               int off;
               chk(lat >= LAT_MIN, "R4 latency floor", lat, LAT_MIN);
               chk(lat <= LAT_MAX, "R5 latency ceiling", lat, LAT_MAX);
               span = (model - lo + MOD) % MOD;
               off  = (sd - lo + MOD) % MOD;
               chk(off <= span, "R3 value in window", sd, lo);
               if (prev_snap >= 0)
                  chk(((sd - prev_snap + MOD) % MOD) < MOD / 2, "R8 no backwards", sd, prev_snap);
               if (frozen) chk(sd == model, "R9 R1 frozen value", sd, model);
               prev_snap = sd;
               n_snap++;
               pend = 0;
            end else if (lat > LAT_MAX) begin
               chk(1'b0, "R5 request unanswered", lat, LAT_MAX);
               pend = 0;
            end
         end else begin
            if (snap_valid) chk(1'b0, "R7 unexpected valid", 1, 0);
            if (req_smp) begin
               pend = 1;
               lat  = 0;
               lo   = model;
            end
         end
         last_valid = snap_valid;
         last_data  = sd;
      end
   end

   task automatic pulse_req();
      @(posedge clk_d);
      #1 rd_req = 1'b1;
      @(posedge clk_d);
      #1 rd_req = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk_d);
      for (int k = 0; k < 40 && pend; k++) @(negedge clk_d);
   endtask

   initial begin
      repeat (4) @(posedge clk_d);
      #1;
      chk(snap_valid == 1'b0, "R2 reset valid", int'(snap_valid), 0);
      chk(snap_data == '0, "R2 reset data", int'(snap_data), 0);
      rst_s_n = 1'b1;
      rst_d_n = 1'b1;
      mon_on  = 1;

      // isolated requests with growing gaps
      for (int i = 0; i < 10; i++) begin
         pulse_req();
         wait_idle();
         repeat (i) @(posedge clk_d);
      end

      // request held high: overlap ignored, counter wraps
      @(posedge clk_d);
      #1 rd_req = 1'b1;
      repeat (600) @(posedge clk_d);
      #1 rd_req = 1'b0;
      wait_idle();

      // irregular counter movement
      en_mode = 2;
      for (int i = 0; i < 20; i++) begin
         pulse_req();
         wait_idle();
         repeat (i % 5) @(posedge clk_d);
      end

      // frozen counter: exact value
      en_mode = 1;
      repeat (20) @(posedge clk_d);
      frozen = 1;
      for (int i = 0; i < 5; i++) begin
         pulse_req();
         wait_idle();
      end
      frozen = 0;
      repeat (4) @(posedge clk_d);

      chk(n_snap >= 40, "R3 snapshots delivered", n_snap, 40);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule